// File: doc/BRIEF.md
# Transmit Header Format Converter

This block sits between a transmit queue and the serial-bus link. The queue holds packets in host layout, one 32-bit quadlet per beat. The wire needs a different header layout. The block reads a valid/ready quadlet stream marked with start and end flags. It emits a valid/ready quadlet stream in wire layout, along with a 2-bit transmit speed for the packet.

Every host packet begins with a control quadlet that exists only for the host. That quadlet carries the speed, a flag that selects the bus for the source ID, the transaction code, and the low half of the first wire header word. The block absorbs this quadlet and does not send it.

For asynchronous packets, the first two wire words are assembled from pieces of the first two host quadlets. The local source ID is inserted where the host held the destination ID. Payload quadlets after the header pass through unchanged.

For PHY packets, only the two quadlets that follow the control quadlet go out on the wire.

Top module: `txhdr_conv`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The first host quadlet of a packet (in_sop=1) is never emitted. Its bits 17:16 appear on out_speed from the first output beat of the packet through its end beat, and out_speed does not change in that span.
- R3: A first quadlet whose bits 7:4 equal 0xE starts a PHY packet. The next two host quadlets are emitted unchanged, the first with out_sop=1 and the second with out_eop=1. Any further host quadlets up to and including the host end beat are dropped.
- R4: For an asynchronous packet (bits 7:4 not 0xE), the first output word is {second quadlet[31:16], first quadlet[15:0]}, with out_sop=1.
- R5: For an asynchronous packet, the second output word is {source ID, second quadlet[15:0]}. The source ID is {bus number in bits 31:22, node_num in bits 21:16}.
- R6: The bus number in the source ID is 0x3FF when bit 23 of the first quadlet is 0. It is bus_num when that bit is 1.
- R7: For an asynchronous packet, host quadlets after the second are emitted unchanged and in order. out_eop follows the host end flag. Idle gaps on the input do not alter the output.
- R8: While out_valid=1 and out_ready=0, out_valid stays 1 and out_data stays unchanged. No beat is lost or repeated under backpressure.
- R9: Between packets, quadlets without in_sop are accepted and dropped. A first quadlet that also carries in_eop produces no output.
- R10: An asynchronous packet whose second quadlet carries in_eop yields exactly two output words, and the second one has out_eop=1.
- R11: A PHY packet that ends on its second host quadlet yields one output beat with both out_sop=1 and out_eop=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_num | input | 6 | Local node number used in the source ID |
| bus_num | input | 10 | Configured bus number used when the remote-bus flag is set |
| in_valid | input | 1 | Host quadlet valid |
| in_ready | output | 1 | Block accepts the host quadlet this cycle |
| in_data | input | 32 | Host quadlet |
| in_sop | input | 1 | First quadlet of a host packet |
| in_eop | input | 1 | Last quadlet of a host packet |
| out_valid | output | 1 | Wire quadlet valid |
| out_ready | input | 1 | Downstream accepts the wire quadlet |
| out_data | output | 32 | Wire quadlet |
| out_sop | output | 1 | First wire quadlet of a packet |
| out_eop | output | 1 | Last wire quadlet of a packet |
| out_speed | output | 2 | Transmit speed of the current packet |

## Verification
The hardest situation to reach is a stall in the middle of the header splice. The two synthesized words come from registers while the input is held off, and the handoff to direct pass-through must drop nothing and repeat nothing. The bench reaches this by sending asynchronous packets while out_ready alternates every cycle or rises only one cycle in three, and it inserts idle gaps between host payload beats. A second hard case is the drain state after a PHY packet that is longer than it should be. The bench sends an extra host quadlet after the PHY pair. It then checks that this quadlet never appears on the output and that the next packet is converted normally.

// File: rtl/txhdr_pkg.sv
package txhdr_pkg;

    localparam int QW         = 32;
    localparam int HALF_W     = QW / 2;
    localparam int NODE_W     = 6;
    localparam int BUS_W      = 10;
    localparam int SPD_W      = 2;
    localparam int TCODE_W    = 4;
    localparam int SPD_LSB    = 16;
    localparam int TCODE_LSB  = 4;
    localparam int REMOTE_BIT = 23;

    localparam logic [TCODE_W-1:0] TCODE_PHY_DEF = 4'hE;
    localparam logic [BUS_W-1:0]   LOCAL_BUS_DEF = '1;

    typedef logic [QW-1:0]     quad_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SECOND   = 3'd1,
        ST_EMIT_DST = 3'd2,
        ST_EMIT_SRC = 3'd3,
        ST_PAYLOAD  = 3'd4,
        ST_PHY      = 3'd5,
        ST_DRAIN    = 3'd6
    } cv_state_e;

    typedef struct packed {
        logic [SPD_W-1:0] speed;
        logic             remote_bus;
        half_t            low_half;
    } lead_info_t;

    typedef struct packed {
        half_t dst_id;
        half_t offs_hi;
        logic  last;
    } second_info_t;

    function automatic lead_info_t parse_lead(input quad_t q);
        lead_info_t r;
        r.speed      = q[SPD_LSB +: SPD_W];
        r.remote_bus = q[REMOTE_BIT];
        r.low_half   = q[HALF_W-1:0];
        return r;
    endfunction

    function automatic second_info_t parse_second(input quad_t q, input logic last);
        second_info_t r;
        r.dst_id  = q[QW-1:HALF_W];
        r.offs_hi = q[HALF_W-1:0];
        r.last    = last;
        return r;
    endfunction

    function automatic logic lead_is_phy(input quad_t q, input logic [TCODE_W-1:0] phy_code);
        return q[TCODE_LSB +: TCODE_W] == phy_code;
    endfunction

    function automatic half_t make_src_id(input logic remote,
                                          input logic [BUS_W-1:0] cfg_bus,
                                          input logic [BUS_W-1:0] local_bus,
                                          input logic [NODE_W-1:0] node);
        logic [BUS_W-1:0] bus_sel;
        bus_sel = remote ? cfg_bus : local_bus;
        return {bus_sel, node};
    endfunction

endpackage

// File: rtl/txhdr_ctrl.sv
module txhdr_ctrl
    import txhdr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      in_sop,
    input  logic      in_eop,
    input  logic      out_ready,
    input  logic      lead_phy,
    input  logic      sec_last,
    output cv_state_e state_q,
    output logic      phy_idx_q,
    output logic      in_ready,
    output logic      out_valid,
    output logic      cap_lead,
    output logic      cap_second
);

    cv_state_e state_d;
    logic      phy_idx_d;
    logic      pass_fire;

    assign pass_fire = in_valid && out_ready;

    always_comb begin
        state_d    = state_q;
        phy_idx_d  = phy_idx_q;
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        cap_lead   = 1'b0;
        cap_second = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid && in_sop) begin
                    cap_lead = 1'b1;
                    if (in_eop) begin
                        state_d = ST_IDLE;
                    end else if (lead_phy) begin
                        state_d   = ST_PHY;
                        phy_idx_d = 1'b0;
                    end else begin
                        state_d = ST_SECOND;
                    end
                end
            end
            ST_SECOND: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    cap_second = 1'b1;
                    state_d    = ST_EMIT_DST;
                end
            end
            ST_EMIT_DST: begin
                out_valid = 1'b1;
                if (out_ready) state_d = ST_EMIT_SRC;
            end
            ST_EMIT_SRC: begin
                out_valid = 1'b1;
                if (out_ready) state_d = sec_last ? ST_IDLE : ST_PAYLOAD;
            end
            ST_PAYLOAD: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                if (pass_fire && in_eop) state_d = ST_IDLE;
            end
            ST_PHY: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                if (pass_fire) begin
                    if (in_eop)         state_d = ST_IDLE;
                    else if (phy_idx_q) state_d = ST_DRAIN;
                    else                phy_idx_d = 1'b1;
                end
            end
            ST_DRAIN: begin
                in_ready = 1'b1;
                if (in_valid && in_eop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            phy_idx_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            phy_idx_q <= phy_idx_d;
        end
    end

endmodule

// File: rtl/txhdr_hold_regs.sv
module txhdr_hold_regs
    import txhdr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_lead,
    input  logic         cap_second,
    input  quad_t        in_data,
    input  logic         in_eop,
    output lead_info_t   lead_q,
    output second_info_t sec_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lead_q <= '0;
            sec_q  <= '0;
        end else begin
            if (cap_lead)   lead_q <= parse_lead(in_data);
            if (cap_second) sec_q  <= parse_second(in_data, in_eop);
        end
    end

endmodule

// File: rtl/txhdr_word_build.sv
module txhdr_word_build
    import txhdr_pkg::*;
#(
    parameter logic [BUS_W-1:0] LOCAL_BUS = LOCAL_BUS_DEF
) (
    input  cv_state_e          state_q,
    input  logic               phy_idx_q,
    input  lead_info_t         lead_q,
    input  second_info_t       sec_q,
    input  quad_t              in_data,
    input  logic               in_eop,
    input  logic [BUS_W-1:0]   bus_num,
    input  logic [NODE_W-1:0]  node_num,
    output quad_t              out_data,
    output logic               out_sop,
    output logic               out_eop
);

    half_t src_id;

    assign src_id = make_src_id(lead_q.remote_bus, bus_num, LOCAL_BUS, node_num);

    always_comb begin
        out_data = '0;
        out_sop  = 1'b0;
        out_eop  = 1'b0;
        unique case (state_q)
            ST_EMIT_DST: begin
                out_data = {sec_q.dst_id, lead_q.low_half};
                out_sop  = 1'b1;
            end
            ST_EMIT_SRC: begin
                out_data = {src_id, sec_q.offs_hi};
                out_eop  = sec_q.last;
            end
            ST_PAYLOAD: begin
                out_data = in_data;
                out_eop  = in_eop;
            end
            ST_PHY: begin
                out_data = in_data;
                out_sop  = !phy_idx_q;
                out_eop  = phy_idx_q || in_eop;
            end
            default: begin
                out_data = '0;
            end
        endcase
    end

endmodule

// File: rtl/txhdr_conv.sv
module txhdr_conv
    import txhdr_pkg::*;
#(
    parameter logic [TCODE_W-1:0] PHY_TCODE = TCODE_PHY_DEF,
    parameter logic [BUS_W-1:0]   LOCAL_BUS = LOCAL_BUS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NODE_W-1:0] node_num,
    input  logic [BUS_W-1:0]  bus_num,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [QW-1:0]     in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [QW-1:0]     out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic [SPD_W-1:0]  out_speed
);

    cv_state_e    state_q;
    logic         phy_idx_q;
    logic         cap_lead;
    logic         cap_second;
    logic         lead_phy;
    lead_info_t   lead_q;
    second_info_t sec_q;

    assign lead_phy = lead_is_phy(in_data, PHY_TCODE);

    txhdr_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .out_ready  (out_ready),
        .lead_phy   (lead_phy),
        .sec_last   (sec_q.last),
        .state_q    (state_q),
        .phy_idx_q  (phy_idx_q),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .cap_lead   (cap_lead),
        .cap_second (cap_second)
    );

    txhdr_hold_regs u_hold (
        .clk        (clk),
        .rst        (rst),
        .cap_lead   (cap_lead),
        .cap_second (cap_second),
        .in_data    (in_data),
        .in_eop     (in_eop),
        .lead_q     (lead_q),
        .sec_q      (sec_q)
    );

    txhdr_word_build #(
        .LOCAL_BUS (LOCAL_BUS)
    ) u_build (
        .state_q   (state_q),
        .phy_idx_q (phy_idx_q),
        .lead_q    (lead_q),
        .sec_q     (sec_q),
        .in_data   (in_data),
        .in_eop    (in_eop),
        .bus_num   (bus_num),
        .node_num  (node_num),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

    assign out_speed = lead_q.speed;

endmodule

// File: rtl/txhdr_conv_chk.sv
module txhdr_conv_chk
    import txhdr_pkg::*;
#(
    parameter logic [BUS_W-1:0] LOCAL_BUS = LOCAL_BUS_DEF
) (
    input logic             clk,
    input logic             rst,
    input cv_state_e        state,
    input logic [BUS_W-1:0] bus_num,
    input logic             out_valid,
    input logic             out_ready,
    input logic [QW-1:0]    out_data,
    input logic             out_sop,
    input logic             out_eop,
    input logic [SPD_W-1:0] out_speed
);

    logic out_fire;
    logic pkt_open_q;

    assign out_fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst)                         pkt_open_q <= 1'b0;
        else if (out_fire && out_eop)    pkt_open_q <= 1'b0;
        else if (out_fire && out_sop)    pkt_open_q <= 1'b1;
    end

    AST_SPEED_HELD: assert property (@(posedge clk) disable iff (rst)
        pkt_open_q |-> $stable(out_speed)); // R2

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !out_valid); // R9

    AST_NO_NESTED_SOP: assert property (@(posedge clk) disable iff (rst)
        (out_fire && out_sop) |-> !pkt_open_q); // R4

    AST_BODY_IN_PKT: assert property (@(posedge clk) disable iff (rst)
        (out_fire && !out_sop) |-> pkt_open_q); // R7

    AST_SRC_BUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_EMIT_SRC) && out_fire) |->
            (out_data[QW-1 -: BUS_W] == LOCAL_BUS || out_data[QW-1 -: BUS_W] == bus_num)); // R6

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_EMIT_DST || state == ST_EMIT_SRC) && out_valid && !out_ready)
            |=> (out_valid && $stable(out_data))); // R8

endmodule

bind txhdr_conv txhdr_conv_chk #(.LOCAL_BUS(LOCAL_BUS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state_q),
    .bus_num   (bus_num),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_speed (out_speed)
);

// File: tb/txhdr_conv_bench.sv
`timescale 1ns/1ps
module txhdr_conv_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  node_num;
    logic [9:0]  bus_num;
    logic        in_valid, in_ready, in_sop, in_eop;
    logic [31:0] in_data;
    logic        out_valid, out_ready, out_sop, out_eop;
    logic [31:0] out_data;
    logic [1:0]  out_speed;

    always #2 clk = ~clk;

    txhdr_conv u_txhdr_conv (
        .clk(clk), .rst(rst), .node_num(node_num), .bus_num(bus_num),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_speed(out_speed)
    );

    int checks = 0;
    int fails  = 0;
    int bp_mode = 0;
    bit finished = 0;

    logic [31:0] tx_w [0:15];
    int          tx_n;
    logic [31:0] ex_w [0:15];
    int          ex_n;
    logic [1:0]  ex_spd;

    logic [31:0] rx_w   [0:255];
    logic        rx_sop [0:255];
    logic        rx_eop [0:255];
    logic [1:0]  rx_spd [0:255];
    int          rx_n = 0;
    int          stall_seen = 0;
    int          stall_bad = 0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_data = '0;

    // Output monitor at the falling edge: records beats that fire at the next rising edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall && (out_valid !== 1'b1 || out_data !== prev_data)) stall_bad++;
            if (out_valid && out_ready && rx_n < 256) begin
                rx_w[rx_n]   = out_data;
                rx_sop[rx_n] = out_sop;
                rx_eop[rx_n] = out_eop;
                rx_spd[rx_n] = out_speed;
                rx_n++;
            end
            prev_stall = out_valid && !out_ready;
            if (prev_stall) stall_seen++;
            prev_data  = out_data;
        end
    end

    task automatic expect_eq(input string tag, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] d, input logic s, input logic e);
        bit took;
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        took = 0;
        while (!took) begin
            @(negedge clk);
            took = in_ready;
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic send_pkt(input bit gaps);
        for (int i = 0; i < tx_n; i++) begin
            push(tx_w[i], i == 0, i == tx_n - 1);
            if (gaps) begin
                @(posedge clk); #1;
            end
        end
    endtask

    task automatic check_pkt(input string tag, input int base);
        int got;
        repeat (30) @(posedge clk);
        #1;
        got = rx_n - base;
        expect_eq(tag, "beat count", got, ex_n);
        for (int i = 0; i < ex_n && i < got; i++) begin
            expect_eq(tag, "data", rx_w[base+i], ex_w[i]);
            expect_eq(tag, "sop", {31'd0, rx_sop[base+i]}, {31'd0, i == 0});
            expect_eq(tag, "eop", {31'd0, rx_eop[base+i]}, {31'd0, i == ex_n - 1});
            expect_eq("R2", "speed", {30'd0, rx_spd[base+i]}, {30'd0, ex_spd});
        end
    endtask

    function automatic logic [15:0] src_of(input logic remote);
        return {(remote ? bus_num : 10'h3FF), node_num};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        expect_eq("R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);
        expect_eq("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        @(posedge clk); #1;
    endtask

    task automatic t_async_local();
        int base = rx_n;
        bp_mode = 0;
        tx_w[0] = 32'h0002_1450; tx_w[1] = 32'hFFC2_ABCD;
        tx_w[2] = 32'hDEAD_0001; tx_w[3] = 32'hDEAD_0002; tx_n = 4;
        ex_w[0] = 32'hFFC2_1450;                       // R4
        ex_w[1] = {src_of(1'b0), 16'hABCD};            // R5
        ex_w[2] = 32'hDEAD_0001; ex_w[3] = 32'hDEAD_0002; ex_n = 4;
        ex_spd = 2'd2;
        send_pkt(0);
        check_pkt("R5", base);
    endtask

    task automatic t_async_remote_bp();
        int base = rx_n;
        int bad0 = stall_bad;
        int seen0 = stall_seen;
        bp_mode = 1;
        tx_w[0] = 32'h0083_2840; tx_w[1] = 32'hFFC7_0040;
        tx_w[2] = 32'h0101_0101; tx_w[3] = 32'h0202_0202; tx_w[4] = 32'h0303_0303; tx_n = 5;
        ex_w[0] = 32'hFFC7_2840;
        ex_w[1] = {src_of(1'b1), 16'h0040};            // R6
        ex_w[2] = 32'h0101_0101; ex_w[3] = 32'h0202_0202; ex_w[4] = 32'h0303_0303; ex_n = 5;
        ex_spd = 2'd3;
        send_pkt(1);
        check_pkt("R6", base);
        base = rx_n;
        bp_mode = 2;
        send_pkt(1);
        check_pkt("R7", base);
        bp_mode = 0;
        expect_eq("R8", "stall changes", stall_bad - bad0, 0);
        expect_eq("R8", "stalls seen", {31'd0, (stall_seen - seen0) > 0}, 32'd1);
    endtask

    task automatic t_async_two();
        int base = rx_n;
        tx_w[0] = 32'h0080_0010; tx_w[1] = 32'h1234_F000; tx_n = 2;
        ex_w[0] = 32'h1234_0010;
        ex_w[1] = {src_of(1'b1), 16'hF000}; ex_n = 2;
        ex_spd = 2'd0;
        send_pkt(0);
        check_pkt("R10", base);
    endtask

    task automatic t_phy();
        int base = rx_n;
        tx_w[0] = 32'h0001_00E0; tx_w[1] = 32'h4123_4567;
        tx_w[2] = 32'hBEDC_BA98; tx_w[3] = 32'h5555_5555; tx_n = 4;
        ex_w[0] = 32'h4123_4567; ex_w[1] = 32'hBEDC_BA98; ex_n = 2;
        ex_spd = 2'd1;
        send_pkt(0);
        check_pkt("R3", base);
        t_async_local();
    endtask

    task automatic t_phy_short();
        int base = rx_n;
        tx_w[0] = 32'h0003_00E0; tx_w[1] = 32'h7777_0000; tx_n = 2;
        ex_w[0] = 32'h7777_0000; ex_n = 1;
        ex_spd = 2'd3;
        send_pkt(0);
        check_pkt("R11", base);
    endtask

    task automatic t_idle_junk();
        int base = rx_n;
        push(32'hAAAA_AAAA, 1'b0, 1'b0);
        push(32'hBBBB_BBBB, 1'b0, 1'b1);
        push(32'h0002_0010, 1'b1, 1'b1);
        ex_n = 0;
        check_pkt("R9", base);
        base = rx_n;
        tx_w[0] = 32'h0000_0050; tx_w[1] = 32'hFFC1_0000; tx_n = 2;
        ex_w[0] = 32'hFFC1_0050;
        ex_w[1] = {src_of(1'b0), 16'h0000}; ex_n = 2;
        ex_spd = 2'd0;
        send_pkt(0);
        check_pkt("R9", base);
    endtask

    initial begin
        int cyc = 0;
        out_ready = 1'b1;
        forever begin
            @(posedge clk); #1;
            cyc++;
            case (bp_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = cyc[0];
                default: out_ready = (cyc % 3 == 2);
            endcase
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; node_num = 6'h2A; bus_num = 10'h155;
        in_valid = 1'b0; in_data = '0; in_sop = 1'b0; in_eop = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_async_local();
        t_async_remote_bp();
        t_async_two();
        t_phy();
        t_phy_short();
        t_idle_junk();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule